// File: doc/BRIEF.md
# Indirect Flash Access Register Window

This block is a 32-bit register slave that lets a host reach a nonvolatile store split into equal regions without mapping the store into its address space. The host picks a region with the region-select register, writes a byte address into the pointer register, and reads the data register. The read returns the 32-bit word at that address in the chosen region. A separate window always shows the word at byte 0x10 of region 0, where a valid image keeps its signature.

The store is an internal word array that stands in for real flash. Reset loads it with a computed pattern. An erase command fills an aligned block with all ones. The erase runs in the background, one word per cycle. The host may keep reading during an erase. Only a second erase command is held back, by dropping `req_ready`. Faults are recorded as sticky bits in an error register, and the host clears them by writing ones. A fault on an address also stores that address.

Top module: `fiw_window`

## Requirements
- R1: After reset, the region-select, pointer, erase, error and fault-address registers all read zero, and `req_ready` is high.
- R2: Reset loads flat word index i (region × words per region + word) with SEED ^ (i × 0x9E3779B1). Index 4 instead holds 0x0FF0A55A, and a read of offset 0x10 returns that word.
- R3: A read of offset 0x00 returns, one cycle later with `rsp_valid` high, the word at pointer bits [RW+1:2] of the selected region. Offset 0x40 is the pointer, offset 0x44 is the region select, and `rsp_valid` follows every accepted read and nothing else.
- R4: A data read whose pointer lies beyond the region (any bit above RW+1 set) returns 0xFFFFFFFF, sets error bit 0 in offset 0x70, and stores the pointer in offset 0x74.
- R5: Writing offset 0x70 clears exactly the error bits written as one. Bits [31:3] of offset 0x70 always read zero.
- R6: A data read with a region select of NUM_REGIONS or above returns 0xFFFFFFFF, sets error bit 2, and leaves offset 0x74 unchanged.
- R7: A write to offset 0x48 takes the erase size from bits [15:0] and the target region from bits [31:24]. The size codes are 0x0010 = 4 words, 0x0080 = 32 words and 0x0100 = 64 words at the default ERASE_SHIFT. The command sets every word of the block that contains the pointer, aligned to the block size, to 0xFFFFFFFF. The region-select register plays no part. The written value reads back at 0x48.
- R8: An erase write with any other size code sets error bit 1 and changes no stored word.
- R9: Offsets outside 0x00, 0x10, 0x40, 0x44, 0x48, 0x70 and 0x74 read zero, and writes to them change nothing.
- R10: The erase writes one word per cycle, starting in the cycle after it is accepted. A data read sampled in the same cycle that a word is erased returns the old content. A read one cycle later returns 0xFFFFFFFF.
- R11: While an erase is running, an erase write is held off with `req_ready` low. All other accesses are accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write strobe, 0 = read strobe |
| req_offset | input | 8 | Register byte offset |
| req_wdata | input | 32 | Write data |
| req_ready | output | 1 | Request accepted this cycle |
| rsp_valid | output | 1 | Read data valid, one cycle after an accepted read |
| rsp_rdata | output | 32 | Read data |

## Verification
The background erase and a host data read can land on the same stored word in the same cycle. The bench sets the pointer to the first word of a block and issues the erase command. It then issues data reads back to back in the next two cycles. The first read must return the preload value and the second must return all ones. This pins the read-before-write order to the exact cycle. In the following cycle the bench also presents a second erase command and expects `req_ready` low until the first erase finishes.

// File: rtl/fiw_pkg.sv
package fiw_pkg;
   localparam logic [7:0] OFF_DATA  = 8'h00;
   localparam logic [7:0] OFF_SIG   = 8'h10;
   localparam logic [7:0] OFF_PTR   = 8'h40;
   localparam logic [7:0] OFF_RSEL  = 8'h44;
   localparam logic [7:0] OFF_ERASE = 8'h48;
   localparam logic [7:0] OFF_ERR   = 8'h70;
   localparam logic [7:0] OFF_FADDR = 8'h74;

   localparam logic [31:0] SIGNATURE = 32'h0FF0A55A;
   localparam int          SIG_WORD  = 4;

   localparam logic [15:0] CODE_SMALL = 16'h0010;
   localparam logic [15:0] CODE_MID   = 16'h0080;
   localparam logic [15:0] CODE_LARGE = 16'h0100;

   localparam int ERR_RANGE  = 0;
   localparam int ERR_CODE   = 1;
   localparam int ERR_REGION = 2;

   function automatic logic [31:0] preload_word(int idx, logic [31:0] seed);
      if (idx == SIG_WORD) return SIGNATURE;
      return seed ^ (32'(idx) * 32'h9E3779B1);
   endfunction
endpackage

// File: rtl/fiw_store.sv
module fiw_store #(
   parameter int          WORDS = 256,
   parameter int          AW    = 8,
   parameter logic [31:0] SEED  = 32'hC3A5_1E00
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [31:0]   wdata,
   input  logic [AW-1:0] raddr,
   output logic [31:0]   rdata
);
   logic [31:0] mem [WORDS];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < WORDS; i++) mem[i] <= fiw_pkg::preload_word(i, SEED);
      end else if (we) begin
         mem[waddr] <= wdata;
      end
   end

   assign rdata = mem[raddr];
endmodule

// File: rtl/fiw_eraser.sv
module fiw_eraser #(
   parameter int AW = 8,
   parameter int CW = 7
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [AW-1:0] base,
   input  logic [CW-1:0] count,
   output logic          busy,
   output logic          we,
   output logic [AW-1:0] waddr
);
   logic [AW-1:0] cur;
   logic [CW-1:0] left;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy <= 1'b0;
         cur  <= '0;
         left <= '0;
      end else if (start && !busy) begin
         busy <= 1'b1;
         cur  <= base;
         left <= count;
      end else if (busy) begin
         cur  <= cur + 1'b1;
         left <= left - 1'b1;
         if (left == CW'(1)) busy <= 1'b0;
      end
   end

   assign we    = busy;
   assign waddr = cur;
endmodule

// File: rtl/fiw_window.sv
module fiw_window #(
   parameter int          NUM_REGIONS  = 4,
   parameter int          REGION_WORDS = 64,
   parameter int          ERASE_SHIFT  = 0,
   parameter logic [31:0] SEED         = 32'hC3A5_1E00
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        req_valid,
   input  logic        req_write,
   input  logic [7:0]  req_offset,
   input  logic [31:0] req_wdata,
   output logic        req_ready,
   output logic        rsp_valid,
   output logic [31:0] rsp_rdata
);
   import fiw_pkg::*;

   localparam int RW    = $clog2(REGION_WORDS);
   localparam int RGW   = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1;
   localparam int AW    = RGW + RW;
   localparam int WORDS = NUM_REGIONS * REGION_WORDS;
   localparam int CW    = $clog2(REGION_WORDS + 1);
   localparam int BLK_S = (16 << ERASE_SHIFT) / 4;
   localparam int BLK_M = (128 << ERASE_SHIFT) / 4;
   localparam int BLK_L = (256 << ERASE_SHIFT) / 4;

   if ((REGION_WORDS & (REGION_WORDS - 1)) != 0 || REGION_WORDS < 4 || RW > 28) begin : g_bad_words
      $error("REGION_WORDS must be a power of two between 4 and 2^28");
   end
   if ((NUM_REGIONS & (NUM_REGIONS - 1)) != 0 || NUM_REGIONS > 128) begin : g_bad_regions
      $error("NUM_REGIONS must be a power of two no larger than 128");
   end
   if (BLK_L > REGION_WORDS) begin : g_bad_shift
      $error("largest erase block exceeds a region");
   end

   logic [31:0]   ptr_q, erase_q, faddr_q;
   logic [7:0]    rsel_q;
   logic [2:0]    err_q;
   logic          busy, st_we;
   logic [AW-1:0] st_waddr, st_raddr, rd_idx, erase_base;
   logic [31:0]   st_rdata, rd_val;
   logic          wr, rd, rgn_ok, range_ok, ergn_ok, blk_ok, erase_hit, start;
   logic [CW-1:0] blk_words;
   logic [RW-1:0] blk_mask;
   logic [2:0]    err_set, err_clr;
   logic          latch;

   assign req_ready = !(busy && req_valid && req_write && req_offset == OFF_ERASE);
   assign wr        = req_valid && req_ready && req_write;
   assign rd        = req_valid && req_ready && !req_write;

   assign rgn_ok   = (rsel_q >> RGW) == 8'd0;
   assign range_ok = ptr_q[31:RW+2] == '0;
   assign rd_idx   = {rsel_q[RGW-1:0], ptr_q[2 +: RW]};
   assign st_raddr = (req_offset == OFF_SIG) ? AW'(SIG_WORD) : rd_idx;

   always_comb begin
      blk_ok    = 1'b1;
      blk_words = '0;
      case (req_wdata[15:0])
         CODE_SMALL: blk_words = CW'(BLK_S);
         CODE_MID:   blk_words = CW'(BLK_M);
         CODE_LARGE: blk_words = CW'(BLK_L);
         default:    blk_ok    = 1'b0;
      endcase
   end

   assign blk_mask   = RW'(blk_words - 1'b1);
   assign ergn_ok    = (req_wdata[31:24] >> RGW) == 8'd0;
   assign erase_base = {req_wdata[24 +: RGW], ptr_q[2 +: RW] & ~blk_mask};
   assign erase_hit  = wr && req_offset == OFF_ERASE;
   assign start      = erase_hit && blk_ok && ergn_ok && range_ok;

   always_comb begin
      err_set = '0;
      latch   = 1'b0;
      if (rd && req_offset == OFF_DATA) begin
         if (!rgn_ok) err_set[ERR_REGION] = 1'b1;
         else if (!range_ok) begin
            err_set[ERR_RANGE] = 1'b1;
            latch              = 1'b1;
         end
      end
      if (erase_hit) begin
         if (!blk_ok) err_set[ERR_CODE] = 1'b1;
         else if (!ergn_ok) err_set[ERR_REGION] = 1'b1;
         else if (!range_ok) begin
            err_set[ERR_RANGE] = 1'b1;
            latch              = 1'b1;
         end
      end
   end

   assign err_clr = (wr && req_offset == OFF_ERR) ? req_wdata[2:0] : 3'b000;

   always_comb begin
      case (req_offset)
         OFF_DATA:  rd_val = (rgn_ok && range_ok) ? st_rdata : '1;
         OFF_SIG:   rd_val = st_rdata;
         OFF_PTR:   rd_val = ptr_q;
         OFF_RSEL:  rd_val = {24'd0, rsel_q};
         OFF_ERASE: rd_val = erase_q;
         OFF_ERR:   rd_val = {29'd0, err_q};
         OFF_FADDR: rd_val = faddr_q;
         default:   rd_val = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ptr_q     <= '0;
         rsel_q    <= '0;
         erase_q   <= '0;
         err_q     <= '0;
         faddr_q   <= '0;
         rsp_valid <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         if (wr && req_offset == OFF_PTR)  ptr_q   <= req_wdata;
         if (wr && req_offset == OFF_RSEL) rsel_q  <= req_wdata[7:0];
         if (erase_hit)                    erase_q <= req_wdata;
         if (latch)                        faddr_q <= ptr_q;
         err_q     <= (err_q & ~err_clr) | err_set;
         rsp_valid <= rd;
         if (rd) rsp_rdata <= rd_val;
      end
   end

   fiw_eraser #(.AW(AW), .CW(CW)) u_eraser (
      .clk(clk), .rst_n(rst_n), .start(start), .base(erase_base), .count(blk_words),
      .busy(busy), .we(st_we), .waddr(st_waddr)
   );

   fiw_store #(.WORDS(WORDS), .AW(AW), .SEED(SEED)) u_store (
      .clk(clk), .rst_n(rst_n), .we(st_we), .waddr(st_waddr), .wdata(32'hFFFF_FFFF),
      .raddr(st_raddr), .rdata(st_rdata)
   );
endmodule

// File: rtl/fiw_window_chk.sv
module fiw_window_chk #(
   parameter int REGION_WORDS = 64
) (
   input logic        clk,
   input logic        rst_n,
   input logic        req_valid,
   input logic        req_write,
   input logic [7:0]  req_offset,
   input logic        req_ready,
   input logic        rsp_valid,
   input logic [31:0] rsp_rdata,
   input logic        busy,
   input logic [31:0] ptr_q
);
   import fiw_pkg::*;
   localparam int RW = $clog2(REGION_WORDS);

   logic rd_acc, reserved;
   int   busy_run;

   assign rd_acc   = req_valid && req_ready && !req_write;
   assign reserved = !(req_offset inside {OFF_DATA, OFF_SIG, OFF_PTR, OFF_RSEL,
                                          OFF_ERASE, OFF_ERR, OFF_FADDR});

   always_ff @(posedge clk) begin
      if (!rst_n) busy_run <= 0;
      else if (busy) busy_run <= busy_run + 1;
      else busy_run <= 0;
   end

   AST_STALL_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      !req_ready |-> busy); // R11
   AST_READ_GETS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
      rd_acc |=> rsp_valid); // R3
   AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
      !(req_valid && !req_write) |=> !rsp_valid); // R3
   AST_ERR_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_acc && req_offset == OFF_ERR) |=> rsp_rdata[31:3] == 29'd0); // R5
   AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_acc && reserved) |=> rsp_rdata == 32'd0); // R9
   AST_OUT_OF_RANGE_ONES: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_acc && req_offset == OFF_DATA && ptr_q[31:RW+2] != '0) |=> rsp_rdata == 32'hFFFF_FFFF); // R4
   AST_ERASE_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
      busy_run <= REGION_WORDS); // R7
endmodule

bind fiw_window fiw_window_chk #(.REGION_WORDS(REGION_WORDS)) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
   .req_offset(req_offset), .req_ready(req_ready), .rsp_valid(rsp_valid),
   .rsp_rdata(rsp_rdata), .busy(busy), .ptr_q(ptr_q)
);

// File: tb/fiw_window_bench.sv
module fiw_window_bench;
   localparam logic [31:0] SEED = 32'hC3A5_1E00;
   localparam logic [31:0] SIG  = 32'h0FF0A55A;
   localparam logic [31:0] ONES = 32'hFFFF_FFFF;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0;
   logic [7:0]  req_offset = '0;
   logic [31:0] req_wdata = '0;
   logic        req_ready, rsp_valid;
   logic [31:0] rsp_rdata;
   int          checks = 0, errors = 0;

   always #5 clk = ~clk;

   fiw_window u_fiw_window (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_offset(req_offset), .req_wdata(req_wdata), .req_ready(req_ready),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
   );

   function automatic logic [31:0] exp_word(int idx);
      return (idx == 4) ? SIG : (SEED ^ (32'(idx) * 32'h9E3779B1));
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %08h expected %08h", req, act, exp);
      end
   endtask

   task automatic bus_wr(logic [7:0] off, logic [31:0] data);
      req_valid = 1'b1; req_write = 1'b1; req_offset = off; req_wdata = data;
      #1;
      while (!req_ready) @(negedge clk);
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0; req_write = 1'b0;
   endtask

   task automatic bus_rd(logic [7:0] off, output logic [31:0] data);
      req_valid = 1'b1; req_write = 1'b0; req_offset = off;
      #1;
      while (!req_ready) @(negedge clk);
      @(posedge clk);
      @(negedge clk);
      if (rsp_valid !== 1'b1) chk("R3 rsp_valid", {31'd0, rsp_valid}, 32'd1);
      data = rsp_rdata;
      req_valid = 1'b0;
   endtask

   task automatic read_word(int rgn, int word, output logic [31:0] data);
      bus_wr(8'h44, 32'(rgn));
      bus_wr(8'h40, 32'(word * 4));
      bus_rd(8'h00, data);
   endtask

   task automatic t_reset;
      logic [31:0] d;
      chk("R1 ready", {31'd0, req_ready}, 32'd1);
      bus_rd(8'h40, d); chk("R1 ptr", d, 0);
      bus_rd(8'h44, d); chk("R1 rsel", d, 0);
      bus_rd(8'h48, d); chk("R1 erase", d, 0);
      bus_rd(8'h70, d); chk("R1 err", d, 0);
      bus_rd(8'h74, d); chk("R1 faddr", d, 0);
   endtask

   task automatic t_signature;
      logic [31:0] d;
      bus_rd(8'h10, d); chk("R2 signature window", d, SIG);
      read_word(0, 4, d); chk("R2 signature via data", d, SIG);
   endtask

   task automatic t_indirect;
      logic [31:0] d;
      read_word(1, 2, d);  chk("R3 region1 word2", d, exp_word(66));
      read_word(3, 63, d); chk("R3 region3 last word", d, exp_word(255));
      read_word(0, 0, d);  chk("R3 region0 word0", d, exp_word(0));
      bus_rd(8'h44, d);    chk("R3 rsel readback", d, 0);
   endtask

   task automatic t_range;
      logic [31:0] d;
      bus_wr(8'h44, 1);
      bus_wr(8'h40, 32'h100);
      bus_rd(8'h00, d); chk("R4 out of range data", d, ONES);
      bus_rd(8'h70, d); chk("R4 range error bit", d, 1);
      bus_rd(8'h74, d); chk("R4 fault address", d, 32'h100);
   endtask

   task automatic t_w1c;
      logic [31:0] d;
      bus_wr(8'h70, 32'hFFFF_FFF6);
      bus_rd(8'h70, d); chk("R5 zero bit keeps error", d, 1);
      bus_wr(8'h70, 1);
      bus_rd(8'h70, d); chk("R5 one clears error", d, 0);
   endtask

   task automatic t_bad_region;
      logic [31:0] d;
      bus_wr(8'h44, 5);
      bus_wr(8'h40, 0);
      bus_rd(8'h00, d); chk("R6 bad region data", d, ONES);
      bus_rd(8'h70, d); chk("R6 region error bit", d, 4);
      bus_rd(8'h74, d); chk("R6 fault address kept", d, 32'h100);
      bus_wr(8'h70, 4);
   endtask

   task automatic t_erase;
      logic [31:0] d;
      bus_wr(8'h44, 0);
      bus_wr(8'h40, 32'h14);
      bus_wr(8'h48, 32'h0200_0010);
      repeat (8) @(negedge clk);
      bus_rd(8'h48, d); chk("R7 erase readback", d, 32'h0200_0010);
      read_word(2, 3, d); chk("R7 below block", d, exp_word(131));
      for (int w = 4; w < 8; w++) begin
         read_word(2, w, d); chk("R7 small block word", d, ONES);
      end
      read_word(2, 8, d); chk("R7 above block", d, exp_word(136));
      read_word(0, 5, d); chk("R7 selected region untouched", d, exp_word(5));
      bus_wr(8'h44, 0);
      bus_wr(8'h40, 0);
      bus_wr(8'h48, 32'h0300_0080);
      repeat (40) @(negedge clk);
      read_word(3, 0, d);  chk("R7 mid block first", d, ONES);
      read_word(3, 31, d); chk("R7 mid block last", d, ONES);
      read_word(3, 32, d); chk("R7 mid block end", d, exp_word(224));
      bus_rd(8'h70, d);    chk("R7 no error", d, 0);
   endtask

   task automatic t_bad_code;
      logic [31:0] d;
      bus_wr(8'h40, 0);
      bus_wr(8'h48, 32'h0100_0020);
      repeat (4) @(negedge clk);
      bus_rd(8'h70, d);   chk("R8 code error bit", d, 2);
      read_word(1, 0, d); chk("R8 store untouched", d, exp_word(64));
      bus_wr(8'h70, 2);
   endtask

   task automatic t_reserved;
      logic [31:0] d;
      bus_wr(8'h40, 32'h0000_0024);
      bus_wr(8'h20, 32'h1234_5678);
      bus_wr(8'h4C, 32'hFFFF_FFFF);
      bus_rd(8'h20, d); chk("R9 reserved 0x20 reads zero", d, 0);
      bus_rd(8'h4C, d); chk("R9 reserved 0x4C reads zero", d, 0);
      bus_rd(8'h40, d); chk("R9 pointer not disturbed", d, 32'h24);
      bus_rd(8'h70, d); chk("R9 no error", d, 0);
   endtask

   task automatic t_collide;
      logic [31:0] d;
      bus_wr(8'h44, 1);
      bus_wr(8'h40, 32'h40);
      bus_wr(8'h48, 32'h0100_0010);
      bus_rd(8'h00, d); chk("R10 same-cycle read old", d, exp_word(80));
      bus_rd(8'h00, d); chk("R10 next read erased", d, ONES);
      req_valid = 1'b1; req_write = 1'b1; req_offset = 8'h48; req_wdata = 32'h0100_0010;
      #1;
      chk("R11 second erase stalled", {31'd0, req_ready}, 0);
      req_valid = 1'b0; req_write = 1'b0;
      #1;
      chk("R11 other access ready", {31'd0, req_ready}, 1);
      @(negedge clk);
      bus_wr(8'h48, 32'h0100_0010);
      repeat (6) @(negedge clk);
      read_word(1, 19, d); chk("R10 block last word", d, ONES);
      read_word(1, 20, d); chk("R10 after block", d, exp_word(84));
   endtask

   initial begin
      #1_000_000;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_signature();
      t_indirect();
      t_range();
      t_w1c();
      t_bad_region();
      t_erase();
      t_bad_code();
      t_reserved();
      t_collide();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule